// File: doc/BRIEF.md
# Flash Software Identification Mode Controller

This block sits beside a flash bank and lets software find out which part it is talking to. It watches the bus for write cycles. A fixed three-write unlock-and-command sequence switches the bank from normal array reads into identification mode. In that mode, two low offsets within any bank return a fixed manufacturer code and a fixed device code instead of array contents. An exit command returns the bank to array reads. The exit is either a lone write or the same unlock prefix ending in the exit code. The exit command also serves as a general return to read mode. It has no effect while the busy input reports an internal program or erase.

The array itself lives outside this block. Its read data enters on `array_rdata` and passes through to `rdata` whenever identification mode is not active. Read results are registered and appear one cycle after the read strobe.

Top module: `fid_idmode_ctrl`

## Requirements
- R1: After a synchronous reset, `rdata` is 0000h and the block is in normal read mode, so the first read returns `array_rdata`.
- R2: Identification mode is entered only by three consecutive write cycles: 00AAh to command address 5555h, then 0055h to 2AAAh, then 0090h to 5555h. Command addresses are matched on `addr[14:0]` and data on all 16 bits of `wdata`.
- R3: In identification mode, a read at bank offset 0 (`addr[17:0]` = 0) returns 00BFh.
- R4: In identification mode, a read at bank offset 1 returns 734Ah.
- R5: The bank bits `addr[19:18]` do not take part in decoding, so both codes appear in every bank. Any other offset read in identification mode returns 0000h.
- R6: In normal mode, a read returns the `array_rdata` value present during the read cycle, on `rdata` one clock after `rd_en`. `rdata` holds its value in cycles without `rd_en`.
- R7: Identification mode is left either by a single write of 00F0h (any address) issued from the idle step, or by 00AAh@5555h, 0055h@2AAAh, 00F0h@5555h.
- R8: An exit command issued in normal mode leaves the block in normal mode, and a following entry sequence still works.
- R9: While `busy` is high during the exit write, the exit is ignored and identification mode stays active. The sequence decoder still returns to its idle step.
- R10: A write that does not match the expected next step of a sequence returns the decoder to its idle step without changing the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| addr | input | 20 | Word address; bits 19:18 select the bank |
| wdata | input | 16 | Write data |
| busy | input | 1 | Internal program or erase in progress |
| array_rdata | input | 16 | Read data from the flash array |
| rdata | output | 16 | Registered read result |

## Verification
The bench targets the exit paths under `busy`. A design that ignored the busy input would drop out of identification mode and return array data where the codes were expected.

It breaks sequences midway, including a wrong address with the right data. A decoder that did not fall back to idle would enter or leave the mode on stray writes.

It reads the codes through every bank value and at a third offset. A decoder that used the bank bits, or only bit 0 of the offset, would return wrong codes.

Random writes biased toward the command words, mixed with reads, are compared against a bench model of the sequence. This catches decoders that skip or reorder steps.

// File: rtl/fid_pkg.sv
package fid_pkg;
  typedef enum logic [1:0] {
    STEP_IDLE = 2'd0,
    STEP_ONE  = 2'd1,
    STEP_TWO  = 2'd2
  } step_t;

  localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
  localparam logic [15:0] CMD_KEY_A     = 16'h00AA;
  localparam logic [15:0] CMD_KEY_B     = 16'h0055;
  localparam logic [15:0] CMD_ENTER_ID  = 16'h0090;
  localparam logic [15:0] CMD_LEAVE_ID  = 16'h00F0;
  localparam logic [15:0] CODE_MAKER    = 16'h00BF;
  localparam logic [15:0] CODE_PART     = 16'h734A;
endpackage

// File: rtl/fid_cmd_seq.sv
module fid_cmd_seq
  import fid_pkg::*;
#(
  parameter int CMD_AW = 15,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              busy,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              id_active
);
  localparam logic [CMD_AW-1:0] ADR_A = CMD_AW'(UNLOCK_ADDR_A);
  localparam logic [CMD_AW-1:0] ADR_B = CMD_AW'(UNLOCK_ADDR_B);

  step_t step_q, step_d;
  logic  id_q, id_d;
  logic  at_a, at_b, is_ka, is_kb, is_ent, is_lv;

  assign at_a   = (cmd_addr == ADR_A);
  assign at_b   = (cmd_addr == ADR_B);
  assign is_ka  = (wdata == DATA_W'(CMD_KEY_A));
  assign is_kb  = (wdata == DATA_W'(CMD_KEY_B));
  assign is_ent = (wdata == DATA_W'(CMD_ENTER_ID));
  assign is_lv  = (wdata == DATA_W'(CMD_LEAVE_ID));

  always_comb begin
    step_d = step_q;
    id_d   = id_q;
    if (wr_en) begin
      step_d = STEP_IDLE;
      case (step_q)
        STEP_IDLE: begin
          if (at_a && is_ka) step_d = STEP_ONE;
          else if (is_lv && !busy) id_d = 1'b0;
        end
        STEP_ONE: begin
          if (at_b && is_kb) step_d = STEP_TWO;
        end
        STEP_TWO: begin
          if (at_a && is_ent) id_d = 1'b1;
          else if (at_a && is_lv && !busy) id_d = 1'b0;
        end
        default: step_d = STEP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= STEP_IDLE;
      id_q   <= 1'b0;
    end else begin
      step_q <= step_d;
      id_q   <= id_d;
    end
  end

  assign id_active = id_q;
endmodule

// File: rtl/fid_read_mux.sv
module fid_read_mux
  import fid_pkg::*;
#(
  parameter int OFS_W  = 18,
  parameter int DATA_W = 16
) (
  input  logic              id_active,
  input  logic [OFS_W-1:0]  offset,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] rd_value
);
  logic [DATA_W-1:0] id_value;

  always_comb begin
    if (offset == OFS_W'(0))      id_value = DATA_W'(CODE_MAKER);
    else if (offset == OFS_W'(1)) id_value = DATA_W'(CODE_PART);
    else                          id_value = '0;
  end

  assign rd_value = id_active ? id_value : array_rdata;
endmodule

// File: rtl/fid_idmode_ctrl.sv
module fid_idmode_ctrl #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int BANK_W = 2,
  parameter int CMD_AW = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int OFS_W = ADDR_W - BANK_W;

  logic              id_active;
  logic [OFS_W-1:0]  offset;
  logic [DATA_W-1:0] rd_value;
  logic              unused_bank;

  assign offset      = addr[OFS_W-1:0];
  assign unused_bank = ^addr[ADDR_W-1:OFS_W];

  fid_cmd_seq #(.CMD_AW(CMD_AW), .DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .busy     (busy),
    .cmd_addr (addr[CMD_AW-1:0]),
    .wdata    (wdata),
    .id_active(id_active)
  );

  fid_read_mux #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_mux (
    .id_active  (id_active),
    .offset     (offset),
    .array_rdata(array_rdata),
    .rd_value   (rd_value)
  );

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_value;
  end
endmodule

// File: rtl/fid_idmode_chk.sv
module fid_idmode_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              busy,
  input logic [DATA_W-1:0] array_rdata,
  input logic [DATA_W-1:0] rdata,
  input logic              id_active
);
  localparam int OFS_W = ADDR_W - BANK_W;

  // R9
  busy_keeps_id_chk: assert property (@(posedge clk) disable iff (rst)
    (id_active && busy) |=> id_active);

  // R2
  enter_needs_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(id_active) |-> $past(wr_en && wdata == DATA_W'(16'h0090)));

  // R7
  leave_needs_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(id_active) |-> $past(wr_en && !busy && wdata == DATA_W'(16'h00F0)));

  // R3
  maker_code_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && id_active && addr[OFS_W-1:0] == '0) |=> rdata == DATA_W'(16'h00BF));

  // R4
  part_code_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && id_active && addr[OFS_W-1:0] == OFS_W'(1)) |=> rdata == DATA_W'(16'h734A));

  // R6
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !id_active) |=> rdata == $past(array_rdata));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !$past(rst)) |=> $stable(rdata));
endmodule

bind fid_idmode_ctrl fid_idmode_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .busy(busy), .array_rdata(array_rdata), .rdata(rdata),
  .id_active(id_active)
);

// File: tb/fid_idmode_ctrl_bench.sv
`timescale 1ns/1ps
module fid_idmode_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        busy = 1'b0;
  logic [15:0] array_rdata = '0;
  logic [15:0] rdata;

  int n_cmp = 0;
  int n_bad = 0;
  logic       m_mode = 1'b0;
  int         m_step = 0;

  always #2.5 clk = ~clk;

  fid_idmode_ctrl u_fid_idmode_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .busy(busy), .array_rdata(array_rdata), .rdata(rdata)
  );

  function automatic logic [15:0] exp_read(input logic mode, input logic [19:0] a,
                                           input logic [15:0] arr);
    if (!mode) return arr;
    if (a[17:0] == 18'd0) return 16'h00BF;
    if (a[17:0] == 18'd1) return 16'h734A;
    return 16'h0000;
  endfunction

  task automatic model_write(input logic [19:0] a, input logic [15:0] d, input logic b);
    logic [14:0] ca;
    int nxt;
    ca = a[14:0];
    nxt = 0;
    if (m_step == 0) begin
      if (ca == 15'h5555 && d == 16'h00AA) nxt = 1;
      else if (d == 16'h00F0 && !b) m_mode = 1'b0;
    end else if (m_step == 1) begin
      if (ca == 15'h2AAA && d == 16'h0055) nxt = 2;
    end else begin
      if (ca == 15'h5555 && d == 16'h0090) m_mode = 1'b1;
      else if (ca == 15'h5555 && d == 16'h00F0 && !b) m_mode = 1'b0;
    end
    m_step = nxt;
  endtask

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [19:0] a, input logic [15:0] d, input logic b);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; busy = b;
    model_write(a, d, b);
    @(negedge clk);
    wr_en = 1'b0; busy = 1'b0;
  endtask

  task automatic do_read(input logic [19:0] a, input string tag);
    logic [15:0] arr;
    logic [15:0] exp;
    arr = 16'($urandom);
    @(negedge clk);
    rd_en = 1'b1; addr = a; array_rdata = arr;
    exp = exp_read(m_mode, a, arr);
    @(negedge clk);
    rd_en = 1'b0; array_rdata = 16'($urandom);
    check(rdata, exp, tag);
  endtask

  task automatic enter_seq(input logic [1:0] bank);
    do_write({bank, 18'h05555}, 16'h00AA, 1'b0);
    do_write({bank, 18'h02AAA}, 16'h0055, 1'b0);
    do_write({bank, 18'h05555}, 16'h0090, 1'b0);
  endtask

  task automatic leave_seq(input logic b);
    do_write(20'h05555, 16'h00AA, b);
    do_write(20'h02AAA, 16'h0055, b);
    do_write(20'h05555, 16'h00F0, b);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rdata, 16'h0000, "R1 reset value");
    do_read(20'h00000, "R1 normal after reset");
    do_read(20'h40001, "R6 passthrough");
    held = rdata;
    repeat (3) begin
      @(negedge clk); array_rdata = 16'($urandom);
    end
    check(rdata, held, "R6 hold without read");

    enter_seq(2'd0);
    do_read(20'h00000, "R3 maker code bank0");
    do_read(20'h00001, "R4 part code bank0");
    for (int b = 1; b < 4; b++) begin
      do_read({2'(b), 18'd0}, "R5 maker code other bank");
      do_read({2'(b), 18'd1}, "R5 part code other bank");
    end
    do_read(20'h00002, "R5 other offset zero");
    do_read(20'h20001, "R5 high offset bit zero");

    do_write(20'h00123, 16'h00F0, 1'b1);
    do_read(20'h00001, "R9 single exit while busy");
    leave_seq(1'b1);
    do_read(20'h00000, "R9 long exit while busy");

    do_write(20'h00777, 16'h00F0, 1'b0);
    do_read(20'h00000, "R7 single exit");
    enter_seq(2'd3);
    do_read(20'hC0001, "R2 entry with bank bits set");
    leave_seq(1'b0);
    do_read(20'h00001, "R7 long exit");

    do_write(20'h05555, 16'h00F0, 1'b0);
    do_read(20'h00000, "R8 exit in normal mode");
    enter_seq(2'd1);
    do_read(20'h00000, "R8 entry after stray exit");

    do_write(20'h05555, 16'h00AA, 1'b0);
    do_write(20'h02AAA, 16'h0055, 1'b0);
    do_write(20'h02AAA, 16'h00F0, 1'b0);
    do_read(20'h00001, "R10 broken exit keeps ID");
    do_write(20'h00000, 16'h00F0, 1'b0);
    do_write(20'h05555, 16'h00AA, 1'b0);
    do_write(20'h01234, 16'h0055, 1'b0);
    do_write(20'h05555, 16'h0090, 1'b0);
    do_read(20'h00000, "R10 broken entry stays normal");
    do_write(20'h05555, 16'h00AA, 1'b0);
    do_write(20'h02AAA, 16'h0055, 1'b0);
    do_write(20'h05555, 16'h0091, 1'b0);
    do_read(20'h00001, "R2 wrong enter code");

    for (int i = 0; i < 600; i++) begin
      int sel;
      logic [19:0] ra;
      sel = int'($urandom_range(0, 9));
      ra = {2'($urandom), 18'($urandom_range(0, 3))};
      case (sel)
        0, 1: do_write({2'($urandom), 18'h05555}, 16'h00AA, ($urandom_range(0, 4) == 0));
        2:    do_write({2'($urandom), 18'h02AAA}, 16'h0055, ($urandom_range(0, 4) == 0));
        3:    do_write({2'($urandom), 18'h05555}, 16'h0090, ($urandom_range(0, 4) == 0));
        4:    do_write(20'($urandom), 16'h00F0, ($urandom_range(0, 3) == 0));
        5:    do_write(20'($urandom), 16'($urandom), 1'b0);
        default: do_read(ra, "R2 R7 R10 random sequence");
      endcase
    end
    finish_run();
  end
endmodule